// File: doc/BRIEF.md
# Fixed-Frequency PWM Cycle Sequencer

This block is the switching-cycle state machine for one rail of a current-mode step-down controller. It runs on a fast system clock. It takes a cycle-start event from one of two sources: an internal oscillator pulse, or the falling edge of an external sync input. It also takes single-bit flags from the analog comparators. From these it produces the high-side and low-side gate commands for the rail.

Each cycle start sets the main latch and turns on the high side after a dead-time gap. A PWM or current-limit trip ends the on-time. After a second dead-time gap the synchronous switch turns on. It normally stays on until the next cycle starts.

When the output is in dropout, the off-time can be skipped for at most three cycles in a row. A minimum off-time is enforced after every on-time. Idle mode and forced-PWM mode each stop the low side on a different current flag, and only idle mode drops cycles at light load. A secondary-feedback-low flag stretches the low-side on-time by a fixed interval.

Top module: `pwm_cycle_seq`

## Requirements
- R1: After reset, and on the clock edge after `rail_en` is low, both `hs_on` and `ls_on` are low. A cycle start that arrives while the rail is disabled causes no pulse.
- R2: A cycle start sampled at clock edge t, with the low side on or both switches off, turns the low side off at edge t+1 and raises `hs_on` at edge t+1+DEAD_CYC.
- R3: A `pwm_trip` or `ilim_trip` sampled while `hs_on` is high drops `hs_on` at that edge. `ls_on` rises DEAD_CYC cycles later.
- R4: In forced-PWM mode with no reverse trip, `ls_on` stays high until the next cycle start. After that start, `hs_on` rises DEAD_CYC cycles after `ls_on` falls.
- R5: A cycle start that arrives while `hs_on` is high and `out_low` is set skips the off-time, at most SKIP_MAX (3) times in a row. The next start ends the on-time. Without `out_low`, a cycle start ends the on-time, so a pulse lasts at most one period minus DEAD_CYC.
- R6: The count of skipped off-times returns to zero at every off-time and while the rail is disabled.
- R7: `hs_on` is not raised again until MIN_OFF_CYC cycles after it fell. A cycle start that is refused because the minimum off-time has not elapsed is held and served as soon as it ends. For a start held from the end of a pulse, the off gap is MIN_OFF_CYC+DEAD_CYC.
- R8: In idle mode (`forced_pwm` low), `zero_cross` turns the low side off at the edge that samples it.
- R9: In forced-PWM mode, `zero_cross` has no effect and `rev_trip` turns the low side off.
- R10: In idle mode, a cycle start with `light_load` set produces no high-side pulse. In forced-PWM mode, `light_load` is ignored.
- R11: If `sec_low` is set when the low side would stop on its current flag, the low side stays on for SEC_EXT_CYC more cycles.
- R12: With `use_ext_sync` high, only a falling edge of `ext_sync` starts a cycle and `osc_tick` is ignored. With `use_ext_sync` low, only `osc_tick` starts a cycle.
- R13: `hs_on` and `ls_on` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rail_en | input | 1 | Rail enable |
| use_ext_sync | input | 1 | 1: cycles start on a falling edge of ext_sync |
| osc_tick | input | 1 | Internal oscillator cycle pulse, one clock wide |
| ext_sync | input | 1 | External synchronisation level |
| forced_pwm | input | 1 | 1: forced fixed-frequency mode, 0: idle mode |
| pwm_trip | input | 1 | PWM comparator trip, ends the on-time |
| ilim_trip | input | 1 | Current-limit trip, ends the on-time |
| out_low | input | 1 | Output below regulation |
| light_load | input | 1 | Minimum-current comparator reports light load |
| zero_cross | input | 1 | Inductor current fell through zero |
| rev_trip | input | 1 | Reverse-current limit reached |
| sec_low | input | 1 | Secondary feedback below threshold |
| hs_on | output | 1 | High-side drive command |
| ls_on | output | 1 | Low-side drive command |

## Verification
The hardest case to reach from the ports is the skip counter starting again from zero after a forced off-time. Reaching it takes a dropout run of four oscillator periods, followed by the held start that waits out the minimum off-time, followed by a second full run of skips. The stimulus holds `out_low` high and places oscillator pulses at exact period offsets from the first rising edge. The expected widths of both pulses then follow from the period, the dead time and the minimum off-time: a counter that failed to restart would shorten the second pulse by three periods.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT,
    ST_DT_HI,
    ST_HIGH,
    ST_DT_LO,
    ST_LOW,
    ST_LOW_EXT
  } seq_state_e;
endpackage

// File: rtl/seq_cycle_src.sv
module seq_cycle_src #(
  parameter bit EDGE_FALL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic use_ext,
  input  logic osc_tick,
  input  logic ext_in,
  output logic cyc_start
);
  logic ext_q;
  logic ext_edge;

  generate
    if (EDGE_FALL) begin : g_fall
      assign ext_edge = ext_q & ~ext_in;
    end else begin : g_rise
      assign ext_edge = ~ext_q & ext_in;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q     <= EDGE_FALL;
      cyc_start <= 1'b0;
    end else begin
      ext_q     <= ext_in;
      cyc_start <= use_ext ? ext_edge : osc_tick;
    end
  end
endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/seq_skip_ctr.sv
module seq_skip_ctr #(
  parameter int SKIP_MAX = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic full
);
  localparam int SW = $clog2(SKIP_MAX + 1);
  localparam logic [SW-1:0] LIMIT = SW'(SKIP_MAX);

  logic [SW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (inc && cnt != LIMIT)
      cnt <= cnt + 1'b1;
  end

  assign full = (cnt == LIMIT);
endmodule

// File: rtl/pwm_cycle_seq.sv
module pwm_cycle_seq
  import pwm_seq_pkg::*;
#(
  parameter int DEAD_CYC    = 12,
  parameter int MIN_OFF_CYC = 60,
  parameter int SEC_EXT_CYC = 200,
  parameter int SKIP_MAX    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic rail_en,
  input  logic use_ext_sync,
  input  logic osc_tick,
  input  logic ext_sync,
  input  logic forced_pwm,
  input  logic pwm_trip,
  input  logic ilim_trip,
  input  logic out_low,
  input  logic light_load,
  input  logic zero_cross,
  input  logic rev_trip,
  input  logic sec_low,
  output logic hs_on,
  output logic ls_on
);
  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam int MW = $clog2(MIN_OFF_CYC + 1);
  localparam int EW = $clog2(SEC_EXT_CYC + 1);
  localparam logic [DW-1:0] DEAD_LD = DW'(DEAD_CYC - 1);
  localparam logic [MW-1:0] MOFF_LD = MW'(MIN_OFF_CYC - 1);
  localparam logic [EW-1:0] EXT_LD  = EW'(SEC_EXT_CYC - 1);

  seq_state_e st, nxt;
  logic cyc_start, pend, pend_nxt;
  logic dead_ld, dead_done, minoff_ld, minoff_done, ext_ld, ext_done;
  logic skip_inc, skip_clr, skip_full;
  logic start_go, light_skip, ls_stop, hi_end;

  seq_cycle_src #(.EDGE_FALL(1'b1)) u_src (
    .clk(clk), .rst(rst), .use_ext(use_ext_sync),
    .osc_tick(osc_tick), .ext_in(ext_sync), .cyc_start(cyc_start)
  );

  seq_timer #(.W(DW)) u_dead (
    .clk(clk), .rst(rst), .load(dead_ld), .load_val(DEAD_LD), .done(dead_done)
  );

  seq_timer #(.W(MW)) u_minoff (
    .clk(clk), .rst(rst), .load(minoff_ld), .load_val(MOFF_LD), .done(minoff_done)
  );

  seq_timer #(.W(EW)) u_secext (
    .clk(clk), .rst(rst), .load(ext_ld), .load_val(EXT_LD), .done(ext_done)
  );

  seq_skip_ctr #(.SKIP_MAX(SKIP_MAX)) u_skip (
    .clk(clk), .rst(rst), .clr(skip_clr), .inc(skip_inc), .full(skip_full)
  );

  assign start_go   = (cyc_start | pend) & minoff_done;
  assign light_skip = ~forced_pwm & light_load;
  assign ls_stop    = forced_pwm ? rev_trip : zero_cross;
  assign hi_end     = pwm_trip | ilim_trip;

  always_comb begin
    nxt       = st;
    dead_ld   = 1'b0;
    minoff_ld = 1'b0;
    ext_ld    = 1'b0;
    skip_inc  = 1'b0;
    skip_clr  = 1'b0;
    pend_nxt  = pend | cyc_start;
    if (!rail_en) begin
      nxt       = ST_OFF;
      pend_nxt  = 1'b0;
      skip_clr  = 1'b1;
      minoff_ld = (st == ST_HIGH);
    end else begin
      case (st)
        ST_OFF: begin
          nxt      = ST_WAIT;
          pend_nxt = 1'b0;
        end
        ST_WAIT, ST_LOW, ST_LOW_EXT: begin
          if (start_go) begin
            pend_nxt = 1'b0;
            if (!light_skip) begin
              nxt     = ST_DT_HI;
              dead_ld = 1'b1;
            end
          end else if (st == ST_LOW && ls_stop) begin
            if (sec_low) begin
              nxt    = ST_LOW_EXT;
              ext_ld = 1'b1;
            end else begin
              nxt = ST_WAIT;
            end
          end else if (st == ST_LOW_EXT && ext_done) begin
            nxt = ST_WAIT;
          end
        end
        ST_DT_HI: begin
          pend_nxt = 1'b0;
          if (dead_done) nxt = ST_HIGH;
        end
        ST_HIGH: begin
          pend_nxt = 1'b0;
          if (hi_end) begin
            nxt       = ST_DT_LO;
            dead_ld   = 1'b1;
            minoff_ld = 1'b1;
            skip_clr  = 1'b1;
          end else if (cyc_start) begin
            if (out_low && !skip_full) begin
              skip_inc = 1'b1;
            end else begin
              nxt       = ST_DT_LO;
              dead_ld   = 1'b1;
              minoff_ld = 1'b1;
              skip_clr  = 1'b1;
              pend_nxt  = 1'b1;
            end
          end
        end
        ST_DT_LO: begin
          if (dead_done) nxt = ST_LOW;
        end
        default: nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_OFF;
      pend  <= 1'b0;
      hs_on <= 1'b0;
      ls_on <= 1'b0;
    end else begin
      st    <= nxt;
      pend  <= pend_nxt;
      hs_on <= (nxt == ST_HIGH);
      ls_on <= (nxt == ST_LOW) || (nxt == ST_LOW_EXT);
    end
  end
endmodule

// File: rtl/pwm_cycle_seq_chk.sv
module pwm_cycle_seq_chk #(
  parameter int MIN_OFF_CYC = 60
) (
  input logic clk,
  input logic rst,
  input logic rail_en,
  input logic hs_on,
  input logic ls_on
);
  localparam int CW = $clog2(MIN_OFF_CYC + 1);
  localparam logic [CW-1:0] CMAX = CW'(MIN_OFF_CYC);

  logic [CW-1:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (rst)
      lo_cnt <= CMAX;
    else if (hs_on)
      lo_cnt <= '0;
    else if (lo_cnt != CMAX)
      lo_cnt <= lo_cnt + 1'b1;
  end

  a_r13_never_both: assert property (@(posedge clk) disable iff (rst)
    !(hs_on && ls_on));

  a_r1_disable_quiet: assert property (@(posedge clk) disable iff (rst)
    !rail_en |=> (!hs_on && !ls_on));

  a_r3_dead_after_high: assert property (@(posedge clk) disable iff (rst)
    $fell(hs_on) |-> !ls_on);

  a_r2_dead_before_high: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_on) |-> !$past(ls_on));

  a_r7_min_off: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_on) |-> (lo_cnt >= CMAX));
endmodule

bind pwm_cycle_seq pwm_cycle_seq_chk #(.MIN_OFF_CYC(MIN_OFF_CYC)) chk_i (
  .clk(clk), .rst(rst), .rail_en(rail_en), .hs_on(hs_on), .ls_on(ls_on)
);

// File: tb/pwm_cycle_seq_tb_top.sv
`timescale 1ns/1ps
module pwm_cycle_seq_tb_top;
  localparam int DEAD = 12;
  localparam int MOFF = 60;
  localparam int SEXT = 200;
  localparam int P    = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rail_en = 0, use_ext_sync = 0, osc_tick = 0, ext_sync = 0;
  logic forced_pwm = 0, pwm_trip = 0, ilim_trip = 0, out_low = 0;
  logic light_load = 0, zero_cross = 0, rev_trip = 0, sec_low = 0;
  logic hs_on, ls_on;

  always #2.5 clk = ~clk;

  pwm_cycle_seq #(.DEAD_CYC(DEAD), .MIN_OFF_CYC(MOFF), .SEC_EXT_CYC(SEXT), .SKIP_MAX(3)) dut_i (
    .clk(clk), .rst(rst), .rail_en(rail_en), .use_ext_sync(use_ext_sync),
    .osc_tick(osc_tick), .ext_sync(ext_sync), .forced_pwm(forced_pwm),
    .pwm_trip(pwm_trip), .ilim_trip(ilim_trip), .out_low(out_low),
    .light_load(light_load), .zero_cross(zero_cross), .rev_trip(rev_trip),
    .sec_low(sec_low), .hs_on(hs_on), .ls_on(ls_on)
  );

  int checks = 0, errors = 0;
  int cyc = 0, hs_rise_at = 0, hs_fall_at = 0, ls_rise_at = 0, ls_fall_at = 0;
  int hs_rises = 0, overlap = 0;
  bit hs_prev = 0, ls_prev = 0;
  int exp_q[$];
  string tag_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor and scoreboard for high-side pulse widths
  always @(negedge clk) begin
    cyc++;
    if (hs_on && ls_on) overlap++;
    if (hs_on && !hs_prev) begin hs_rise_at = cyc; hs_rises++; end
    if (!hs_on && hs_prev) begin
      hs_fall_at = cyc;
      if (exp_q.size() > 0) begin
        int e; string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk((cyc - hs_rise_at) == e, t, cyc - hs_rise_at, e);
      end
    end
    if (ls_on && !ls_prev) ls_rise_at = cyc;
    if (!ls_on && ls_prev) ls_fall_at = cyc;
    hs_prev = hs_on;
    ls_prev = ls_on;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    osc_tick = 1'b1;
    @(negedge clk);
    osc_tick = 1'b0;
  endtask

  task automatic wait_hs(output int n);
    n = 0;
    while (!hs_on && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_ls();
    int n = 0;
    while (!ls_on && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic expect_hs(input int w, input string t);
    exp_q.push_back(w);
    tag_q.push_back(t);
  endtask

  task automatic pulse_trip(input bit use_ilim, input int n);
    step(n - 1);
    if (use_ilim) ilim_trip = 1'b1; else pwm_trip = 1'b1;
    step(1);
    ilim_trip = 1'b0;
    pwm_trip  = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    int n, snap;
    step(5);
    rst = 1'b0;
    step(1);
    chk(!hs_on && !ls_on, "R1 reset", {hs_on, ls_on}, 0);

    // disabled rail ignores a cycle start
    tick();
    step(30);
    chk(hs_rises == 0, "R1 disabled", hs_rises, 0);

    rail_en = 1'b1; forced_pwm = 1'b1;
    step(4);
    tick();
    wait_hs(n);
    chk(n == DEAD + 1, "R2 start latency from idle", n, DEAD + 1);
    expect_hs(40, "R3 pwm trip width");
    pulse_trip(1'b0, 40);
    step(30);
    chk(ls_on == 1'b1, "R3 low side on", ls_on, 1);
    chk(ls_rise_at - hs_fall_at == DEAD, "R3 dead time", ls_rise_at - hs_fall_at, DEAD);
    step(200);
    chk(ls_on == 1'b1, "R4 low side held", ls_on, 1);
    tick();
    wait_hs(n);
    chk(n == DEAD + 1, "R2 start latency from low", n, DEAD + 1);
    step(2);
    chk(hs_rise_at - ls_fall_at == DEAD, "R4 dead before high", hs_rise_at - ls_fall_at, DEAD);
    expect_hs(25, "R3 current limit width");
    pulse_trip(1'b1, 23);
    step(30);

    // forced-PWM mode: zero-cross ignored, reverse trip stops low side
    zero_cross = 1'b1; step(1); zero_cross = 1'b0;
    step(5);
    chk(ls_on == 1'b1, "R9 zero cross ignored", ls_on, 1);
    rev_trip = 1'b1; step(1); rev_trip = 1'b0;
    step(2);
    chk(ls_on == 1'b0, "R9 reverse trip", ls_on, 0);

    // maximum duty: cycle start ends the pulse when in regulation
    step(80);
    tick();
    wait_hs(n);
    expect_hs(P - DEAD, "R5 end at cycle start");
    step(P - DEAD - 2);
    tick();
    step(100);
    chk(hs_rise_at - hs_fall_at == MOFF + DEAD, "R7 held start after min off", hs_rise_at - hs_fall_at, MOFF + DEAD);
    rail_en = 1'b0;
    step(1);
    chk(!hs_on && !ls_on, "R1 disable mid pulse", {hs_on, ls_on}, 0);
    step(2);
    rail_en = 1'b1;
    step(80);

    // dropout: three skipped off-times then forced off, counter restarts
    out_low = 1'b1;
    tick();
    wait_hs(n);
    expect_hs(4 * P - DEAD, "R5 three skips");
    step(P - DEAD - 2);
    tick();
    for (int i = 0; i < 3; i++) begin step(P - 1); tick(); end
    expect_hs(4 * P - MOFF - DEAD, "R6 skip count restarts");
    for (int i = 0; i < 4; i++) begin step(P - 1); tick(); end
    step(5);
    chk(exp_q.size() == 0, "R6 dropout pulses seen", exp_q.size(), 0);
    out_low = 1'b0;
    rail_en = 1'b0;
    step(2);
    rail_en = 1'b1;
    step(80);

    // idle mode: zero-cross ends the low side
    forced_pwm = 1'b0;
    tick();
    wait_hs(n);
    expect_hs(30, "R3 idle width");
    pulse_trip(1'b0, 30);
    wait_ls();
    step(19);
    zero_cross = 1'b1; step(1); zero_cross = 1'b0;
    step(3);
    chk(!ls_on && (ls_fall_at - ls_rise_at == 20), "R8 zero cross stop", ls_fall_at - ls_rise_at, 20);
    step(80);

    // secondary feedback stretch
    tick();
    wait_hs(n);
    expect_hs(30, "R3 idle width 2");
    pulse_trip(1'b0, 30);
    wait_ls();
    sec_low = 1'b1;
    step(19);
    zero_cross = 1'b1; step(1); zero_cross = 1'b0;
    step(SEXT + 10);
    chk(!ls_on && (ls_fall_at - ls_rise_at == 20 + SEXT), "R11 low side stretch", ls_fall_at - ls_rise_at, 20 + SEXT);
    sec_low = 1'b0;
    step(80);

    // light load
    light_load = 1'b1;
    snap = hs_rises;
    tick();
    step(60);
    chk(hs_rises == snap && !hs_on, "R10 light load skip", hs_rises - snap, 0);
    forced_pwm = 1'b1;
    tick();
    wait_hs(n);
    chk(n == DEAD + 1, "R10 light load ignored in forced PWM", n, DEAD + 1);
    expect_hs(10, "R3 short width");
    pulse_trip(1'b0, 10);
    light_load = 1'b0;
    step(80);

    // external sync
    ext_sync = 1'b1;
    step(3);
    use_ext_sync = 1'b1;
    step(3);
    snap = hs_rises;
    tick();
    step(60);
    chk(hs_rises == snap, "R12 osc ignored in ext mode", hs_rises - snap, 0);
    ext_sync = 1'b0;
    step(1);
    wait_hs(n);
    chk(n == DEAD + 1, "R12 falling sync edge start", n, DEAD + 1);
    expect_hs(15, "R3 sync width");
    pulse_trip(1'b0, 15);
    step(80);
    snap = hs_rises;
    ext_sync = 1'b1;
    step(60);
    chk(hs_rises == snap, "R12 rising sync edge ignored", hs_rises - snap, 0);
    use_ext_sync = 1'b0;
    step(3);
    ext_sync = 1'b0;
    step(60);
    chk(hs_rises == snap, "R12 sync ignored in internal mode", hs_rises - snap, 0);

    chk(overlap == 0, "R13 no overlap", overlap, 0);
    chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule